// File: doc/BRIEF.md
# Three-Phase Power Combiner with Reverse-Power Flag

This block takes three signed per-phase real-power words and produces the total power word that feeds a downstream digital-to-frequency converter. A mode pin selects the combining rule. In signed mode the three words are added as they are. In magnitude mode the absolute value of each word is added. The total is registered, so it appears one clock after its inputs are presented.

The block also drives a reverse-power flag. The flag reports whether any phase that is carrying load shows negative real power, which means its voltage-current angle is beyond 90 degrees. The flag is evaluated only on the clock edge where the calibration-pulse strobe is high, and it holds its value between strobes. A phase marked as idle (below the no-load threshold) takes no part in the decision. The flag is not sticky: a later strobe at which no active phase is negative clears it. The sign test works the same way in both combining modes.

Top module: `tps_sum_negflag`

## Requirements
- R1: With `sum_signed` high, `total_pwr` equals the two's-complement sum A+B+C of the three phase words, one clock after they are presented. Phase A is `phase_pwr[W-1:0]`, phase B is `phase_pwr[2W-1:W]` and phase C is `phase_pwr[3W-1:2W]`, each signed.
- R2: With `sum_signed` low, `total_pwr` equals |A|+|B|+|C|, one clock after the inputs are presented, and is never negative.
- R3: On a clock edge where `cal_strobe` is high and at least one phase with its `phase_idle` bit low has a negative word, `rev_flag` is high from the next cycle.
- R4: On a clock edge where `cal_strobe` is high and no non-idle phase is negative, `rev_flag` is low from the next cycle. A word of zero counts as not negative.
- R5: On edges where `cal_strobe` is low, `rev_flag` keeps its value, whatever the phase words, idle bits or mode do.
- R6: A phase whose `phase_idle` bit is high (bit 0 is A, bit 1 is B, bit 2 is C) is left out of the negative-power decision, even when its word is negative.
- R7: The flag decision at a strobe does not depend on `sum_signed`.
- R8: While `rst_n` is low, `total_pwr` is 0 and `rev_flag` is low.
- R9: `total_pwr` is W+2 bits wide. With all three phases at full-scale negative (-2^(W-1)), it reads -3*2^(W-1) in signed mode and +3*2^(W-1) in magnitude mode, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sum_signed | input | 1 | 1: signed sum, 0: sum of magnitudes |
| phase_pwr | input | 3*W | Three signed phase-power words, phase A in the low bits |
| phase_idle | input | 3 | Per-phase no-load indication, bit 0 = A |
| cal_strobe | input | 1 | Calibration-pulse event; the flag is updated on this edge |
| total_pwr | output | W+2 | Registered total power, signed |
| rev_flag | output | 1 | Reverse-power flag |

## Verification
Both results come out of a single register stage. `total_pwr` reflects the inputs present at the rising edge before it is read, and `rev_flag` changes only one cycle after an edge with `cal_strobe` high. The bench drives inputs on the falling edge and reads both outputs on the next falling edge, which is exactly one rising edge later. Its reference model updates the expected flag only when it issues a strobe. Every combination of a 4-bit configuration is swept in both modes, and the strobe and idle patterns vary with the data. Directed sequences then cover holding between strobes, clearing, and the full-scale corner.

// File: rtl/tps_pkg.sv
package tps_pkg;
    typedef enum logic {
        SUM_MAGNITUDE = 1'b0,
        SUM_SIGNED    = 1'b1
    } sum_mode_e;

    localparam int NUM_PHASES = 3;
endpackage

// File: rtl/tps_phase_cond.sv
module tps_phase_cond #(
    parameter int W  = 16,
    parameter int SW = W + 2
) (
    input  logic signed [W-1:0]  pwr,
    input  logic                 idle,
    output logic signed [SW-1:0] ext_val,
    output logic signed [SW-1:0] mag_val,
    output logic                 neg_active
);
    // Widen first so that the magnitude of the most negative code fits.
    always_comb begin
        ext_val    = SW'(pwr);
        mag_val    = ext_val[SW-1] ? -ext_val : ext_val;
        neg_active = pwr[W-1] & ~idle;
    end
endmodule

// File: rtl/tps_adder3.sv
module tps_adder3 #(
    parameter int SW = 18
) (
    input  logic signed [SW-1:0] in_a,
    input  logic signed [SW-1:0] in_b,
    input  logic signed [SW-1:0] in_c,
    output logic signed [SW-1:0] sum
);
    always_comb begin
        sum = in_a + in_b + in_c;
    end
endmodule

// File: rtl/tps_sum_negflag.sv
module tps_sum_negflag #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sum_signed,
    input  logic [3*W-1:0]       phase_pwr,
    input  logic [2:0]           phase_idle,
    input  logic                 cal_strobe,
    output logic signed [W+1:0]  total_pwr,
    output logic                 rev_flag
);
    import tps_pkg::*;

    localparam int SW = W + 2;
    localparam int NP = NUM_PHASES;

    typedef struct packed {
        logic signed [SW-1:0] total;
        logic                 neg;
    } state_t;

    logic signed [SW-1:0] ext_v [NP];
    logic signed [SW-1:0] mag_v [NP];
    logic [NP-1:0]        neg_v;
    logic signed [SW-1:0] sum_signed_v;
    logic signed [SW-1:0] sum_mag_v;
    sum_mode_e            mode;

    state_t st_d, st_q;

    genvar gi;
    generate
        for (gi = 0; gi < NP; gi++) begin : g_phase
            tps_phase_cond #(.W(W), .SW(SW)) u_cond (
                .pwr        (phase_pwr[gi*W +: W]),
                .idle       (phase_idle[gi]),
                .ext_val    (ext_v[gi]),
                .mag_val    (mag_v[gi]),
                .neg_active (neg_v[gi])
            );
        end
    endgenerate

    tps_adder3 #(.SW(SW)) u_add_signed (
        .in_a (ext_v[0]), .in_b (ext_v[1]), .in_c (ext_v[2]),
        .sum  (sum_signed_v)
    );

    tps_adder3 #(.SW(SW)) u_add_mag (
        .in_a (mag_v[0]), .in_b (mag_v[1]), .in_c (mag_v[2]),
        .sum  (sum_mag_v)
    );

    always_comb begin
        mode     = sum_mode_e'(sum_signed);
        st_d     = st_q;
        st_d.total = (mode == SUM_SIGNED) ? sum_signed_v : sum_mag_v;
        if (cal_strobe) begin
            st_d.neg = |neg_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign total_pwr = st_q.total;
    assign rev_flag  = st_q.neg;

    // Flag only moves on a calibration event.
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_strobe |=> $stable(rev_flag));

    // A loaded negative phase at a strobe raises the flag.
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_strobe && |(~phase_idle & {phase_pwr[3*W-1], phase_pwr[2*W-1], phase_pwr[W-1]}))
        |=> rev_flag);

    // No loaded negative phase at a strobe clears the flag.
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_strobe && !(|(~phase_idle & {phase_pwr[3*W-1], phase_pwr[2*W-1], phase_pwr[W-1]})))
        |=> !rev_flag);

    // Idle phases never raise the flag.
    p_idle_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_strobe && (phase_idle == 3'b111)) |=> !rev_flag);

    // Magnitude mode never yields a negative total.
    p_mag_nonneg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_signed |=> !total_pwr[W+1]);
endmodule

// File: tb/tps_sum_negflag_test.sv
module tps_sum_negflag_test;
    localparam int W  = 4;
    localparam int SW = W + 2;
    localparam int LO = -(1 << (W-1));
    localparam int HI = (1 << (W-1)) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sum_signed = 1'b0;
    logic [3*W-1:0]       phase_pwr = '0;
    logic [2:0]           phase_idle = '0;
    logic                 cal_strobe = 1'b0;
    logic signed [SW-1:0] total_pwr;
    logic                 rev_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int exp_total = 0;
    bit exp_flag = 1'b0;

    always #2 clk = ~clk;

    tps_sum_negflag #(.W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sum_signed (sum_signed),
        .phase_pwr  (phase_pwr),
        .phase_idle (phase_idle),
        .cal_strobe (cal_strobe),
        .total_pwr  (total_pwr),
        .rev_flag   (rev_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Drive one stimulus on a falling edge, then read the outputs one rising edge later.
    task automatic apply(input int a, input int b, input int c, input bit mode,
                         input logic [2:0] idle, input bit strobe);
        logic [W-1:0] wa, wb, wc;
        wa = a[W-1:0]; wb = b[W-1:0]; wc = c[W-1:0];
        phase_pwr  = {wc, wb, wa};
        sum_signed = mode;
        phase_idle = idle;
        cal_strobe = strobe;
        exp_total  = mode ? (a + b + c) : (iabs(a) + iabs(b) + iabs(c));
        if (strobe)
            exp_flag = ((a < 0) && !idle[0]) || ((b < 0) && !idle[1]) || ((c < 0) && !idle[2]);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        phase_pwr = {4'(-1), 4'(-2), 4'(-3)};
        sum_signed = 1'b1;
        cal_strobe = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 total in reset", int'(total_pwr), 0);
        check("R8 flag in reset", int'(rev_flag), 0);
        rst_n = 1'b1;
        cal_strobe = 1'b0;
        @(negedge clk);

        // Exhaustive sweep: both modes, every value triple, data-derived strobe and idle.
        for (int m = 0; m < 2; m++) begin
            for (int a = LO; a <= HI; a++) begin
                for (int b = LO; b <= HI; b++) begin
                    for (int c = LO; c <= HI; c++) begin
                        logic [2:0] idl;
                        bit stb;
                        idl = 3'((a + 2*b + 3*c + m) & 7);
                        stb = ((a ^ b ^ c) & 1) == 1;
                        apply(a, b, c, m[0], idl, stb);
                        if (m == 1) check("R1 signed sum", int'(total_pwr), exp_total);
                        else        check("R2 magnitude sum", int'(total_pwr), exp_total);
                        check("R3 R4 R5 R6 R7 flag", int'(rev_flag), int'(exp_flag));
                    end
                end
            end
        end

        // R9: full-scale negative corner in both modes.
        apply(LO, LO, LO, 1'b1, 3'b000, 1'b1);
        check("R9 full-scale signed", int'(total_pwr), 3*LO);
        check("R3 full-scale flag", int'(rev_flag), 1);
        apply(LO, LO, LO, 1'b0, 3'b000, 1'b0);
        check("R9 full-scale magnitude", int'(total_pwr), -3*LO);

        // R5: flag held while phases go positive without a strobe.
        apply(3, 2, 1, 1'b1, 3'b000, 1'b0);
        check("R5 hold high", int'(rev_flag), 1);
        apply(HI, HI, HI, 1'b0, 3'b000, 1'b0);
        check("R5 hold high second", int'(rev_flag), 1);
        // R4: zero and positive at a strobe clear the flag.
        apply(0, 0, 5, 1'b1, 3'b000, 1'b1);
        check("R4 clear on zero/positive", int'(rev_flag), 0);
        // R5: negative phases without a strobe do not set it.
        apply(-1, -2, -3, 1'b1, 3'b000, 1'b0);
        check("R5 hold low", int'(rev_flag), 0);
        // R6: a negative idle phase is excluded.
        apply(2, -4, 2, 1'b0, 3'b010, 1'b1);
        check("R6 idle phase ignored", int'(rev_flag), 0);
        // R6: it counts again once no longer idle.
        apply(2, -4, 2, 1'b0, 3'b000, 1'b1);
        check("R6 phase rejoins", int'(rev_flag), 1);
        // R7: same decision in magnitude mode, cleared later.
        apply(1, 1, -1, 1'b0, 3'b011, 1'b1);
        check("R7 magnitude mode detect", int'(rev_flag), 1);
        check("R2 total with negative phase", int'(total_pwr), 3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule